// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address. It reads a two-level translation tree held in ordinary memory. A request carries the virtual address and the value of the translation root register. The walker then performs one or two dependent word reads through a simple request/valid memory port:

- The first read fetches the directory entry.
- The second read fetches the page entry that the directory entry points at.

When the walk ends, the walker raises a one-cycle completion pulse. The pulse carries either the physical address or a fault flag, and the fault flag comes with the level at which the walk stopped. A successful walk also raises a fill record, which a translation cache next to the walker can store directly.

Every entry is a 32-bit word:

- Bit 0 is the present flag.
- Bits 31:12 hold a frame number. In a directory entry this frame locates the second-level table. In a page entry it is the physical page.

The remaining entry bits are not interpreted. Each table begins on a 4 KiB boundary, and the address of an entry is the table start plus four times its index. The walker accepts one request at a time and keeps at most one memory read outstanding.

Top module: `ptw_walker`

## Requirements
- R1: While `rst` is high, and in the cycle after it is sampled high, `busy`, `done`, `mem_rd_req` and `fill_valid` are 0. Reset leaves no read outstanding. A read response that arrives later for a read abandoned by reset produces no `done`.
- R2: A request (`req_valid` high) is accepted only when `busy` is low. In the cycle after acceptance, `busy` is 1. A request presented while `busy` is high is ignored, and the walk in progress completes with its own result.
- R3: In the cycle after acceptance, `mem_rd_req` pulses for one cycle. The read address is `{req_dir_base[31:12], 12'h000} + 4*req_vaddr[31:22]`; bits 11:0 of the root value are ignored. `mem_rd_addr` stays stable until `mem_rd_valid` answers the read.
- R4: If the directory entry has bit 0 set, the second read goes to `{dir_entry[31:12], 12'h000} + 4*vaddr[21:12]`.
- R5: At most one read is outstanding, so `mem_rd_req` never rises while a read is unanswered. While no read is outstanding, `mem_rd_valid` has no effect.
- R6: On success, `done` carries `fault`=0 and `resp_paddr = {pte[31:12], vaddr[11:0]}`. Entry bits 11:1 do not affect the result.
- R7: A directory entry with bit 0 clear ends the walk with `fault`=1 and `fault_level`=0 (directory). No second read is issued.
- R8: A page entry with bit 0 clear ends the walk with `fault`=1 and `fault_level`=1 (page table), after exactly two reads.
- R9: `done` is a single-cycle pulse. `busy` stays 1 from the cycle after acceptance through the `done` cycle, and is 0 in the cycle after it.
- R10: `fill_valid` pulses together with `done` only on success, with `fill_vpn = vaddr[31:12]` and `fill_ppn = pte[31:12]`. On a fault, `resp_paddr` is 0 and `fill_valid` is 0.
- R11: The result is the same whatever the number of wait cycles before each `mem_rd_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request |
| req_vaddr | input | 32 | Virtual address to translate |
| req_dir_base | input | 32 | Root register value; bits 31:12 give the directory frame |
| busy | output | 1 | Walk in progress |
| mem_rd_req | output | 1 | One-cycle word read request |
| mem_rd_addr | output | 32 | Byte address of the entry being read |
| mem_rd_valid | input | 1 | Read data valid |
| mem_rd_data | input | 32 | Entry word returned by memory |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | Walk hit a non-present entry (valid with done) |
| fault_level | output | 1 | 0 = directory, 1 = page table (valid with done and fault) |
| resp_paddr | output | 32 | Translated physical address, 0 on fault |
| fill_valid | output | 1 | Fill record for the translation cache is valid |
| fill_vpn | output | 20 | Virtual page number of the fill |
| fill_ppn | output | 20 | Physical page number of the fill |

## Verification
The assertions take for granted that memory answers every read with exactly one `mem_rd_valid`, and only after seeing the read. The address-stability and single-outstanding checks track the open read on that basis. The bench's memory model answers each request once, after a delay set per walk, and produces spurious `mem_rd_valid` pulses only while the walker is idle. After a reset in the middle of a walk, the bench lets the stale response drain before it issues the next request, so a late answer is never matched against a new read.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_READ_DIR = 3'd1,
    ST_READ_PTE = 3'd2,
    ST_DONE     = 3'd3,
    ST_FAULT    = 3'd4
  } walk_state_e;

  localparam logic LVL_DIR = 1'b0;
  localparam logic LVL_PTE = 1'b1;

endpackage

// File: rtl/ptw_entry_addr.sv
module ptw_entry_addr #(
  parameter int PA_W       = 32,
  parameter int OFF_W      = 12,
  parameter int IDX_W      = 10,
  parameter int ENTRY_LOG2 = 2
) (
  input  logic [PA_W-OFF_W-1:0] frame,
  input  logic [IDX_W-1:0]      idx,
  output logic [PA_W-1:0]       addr
);
  logic [PA_W-1:0] table_start;
  logic [PA_W-1:0] entry_step;

  assign table_start = {frame, {OFF_W{1'b0}}};
  assign entry_step  = PA_W'(idx) << ENTRY_LOG2;
  assign addr        = table_start + entry_step;
endmodule

// File: rtl/ptw_seq.sv
module ptw_seq
  import ptw_pkg::*;
#(
  parameter int VA_W = 32,
  parameter int PA_W = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            req_valid,
  input  logic [VA_W-1:0] req_vaddr,
  input  logic [PA_W-1:0] dir_addr,
  input  logic [PA_W-1:0] pte_addr,
  input  logic            mem_rd_valid,
  input  logic            entry_present,
  output logic            mem_rd_req,
  output logic [PA_W-1:0] mem_rd_addr,
  output logic            busy,
  output logic [VA_W-1:0] vaddr_q,
  output logic            end_ev,
  output logic            end_fault,
  output logic            end_level
);
  walk_state_e     state_q, state_d;
  logic            issue;
  logic [PA_W-1:0] issue_addr;

  always_comb begin
    state_d    = state_q;
    issue      = 1'b0;
    issue_addr = '0;
    end_ev     = 1'b0;
    end_fault  = 1'b0;
    end_level  = LVL_DIR;
    case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          state_d    = ST_READ_DIR;
          issue      = 1'b1;
          issue_addr = dir_addr;
        end
      end
      ST_READ_DIR: begin
        if (mem_rd_valid) begin
          if (entry_present) begin
            state_d    = ST_READ_PTE;
            issue      = 1'b1;
            issue_addr = pte_addr;
          end else begin
            state_d   = ST_FAULT;
            end_ev    = 1'b1;
            end_fault = 1'b1;
            end_level = LVL_DIR;
          end
        end
      end
      ST_READ_PTE: begin
        if (mem_rd_valid) begin
          end_ev    = 1'b1;
          end_level = LVL_PTE;
          end_fault = !entry_present;
          state_d   = entry_present ? ST_DONE : ST_FAULT;
        end
      end
      ST_DONE, ST_FAULT: state_d = ST_IDLE;
      default:           state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      mem_rd_req  <= 1'b0;
      mem_rd_addr <= '0;
      busy        <= 1'b0;
      vaddr_q     <= '0;
    end else begin
      state_q    <= state_d;
      mem_rd_req <= issue;
      busy       <= (state_d != ST_IDLE);
      if (issue) mem_rd_addr <= issue_addr;
      if (state_q == ST_IDLE && req_valid) vaddr_q <= req_vaddr;
    end
  end
endmodule

// File: rtl/ptw_resp.sv
module ptw_resp #(
  parameter int VA_W  = 32,
  parameter int PA_W  = 32,
  parameter int OFF_W = 12
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  end_ev,
  input  logic                  end_fault,
  input  logic                  end_level,
  input  logic [PA_W-OFF_W-1:0] end_frame,
  input  logic [VA_W-1:0]       vaddr_q,
  output logic                  done,
  output logic                  fault,
  output logic                  fault_level,
  output logic [PA_W-1:0]       resp_paddr,
  output logic                  fill_valid,
  output logic [VA_W-OFF_W-1:0] fill_vpn,
  output logic [PA_W-OFF_W-1:0] fill_ppn
);
  always_ff @(posedge clk) begin
    if (rst) begin
      done        <= 1'b0;
      fault       <= 1'b0;
      fault_level <= 1'b0;
      resp_paddr  <= '0;
      fill_valid  <= 1'b0;
      fill_vpn    <= '0;
      fill_ppn    <= '0;
    end else begin
      done       <= end_ev;
      fill_valid <= end_ev && !end_fault;
      if (end_ev) begin
        fault       <= end_fault;
        fault_level <= end_level;
        resp_paddr  <= end_fault ? '0 : {end_frame, vaddr_q[OFF_W-1:0]};
        if (!end_fault) begin
          fill_vpn <= vaddr_q[VA_W-1:OFF_W];
          fill_ppn <= end_frame;
        end
      end
    end
  end
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker #(
  parameter int VA_W       = 32,
  parameter int PA_W       = 32,
  parameter int OFF_W      = 12,
  parameter int ENTRY_LOG2 = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  req_valid,
  input  logic [VA_W-1:0]       req_vaddr,
  input  logic [PA_W-1:0]       req_dir_base,
  output logic                  busy,
  output logic                  mem_rd_req,
  output logic [PA_W-1:0]       mem_rd_addr,
  input  logic                  mem_rd_valid,
  input  logic [PA_W-1:0]       mem_rd_data,
  output logic                  done,
  output logic                  fault,
  output logic                  fault_level,
  output logic [PA_W-1:0]       resp_paddr,
  output logic                  fill_valid,
  output logic [VA_W-OFF_W-1:0] fill_vpn,
  output logic [PA_W-OFF_W-1:0] fill_ppn
);
  localparam int LEVELS  = 2;
  localparam int IDX_W   = (VA_W - OFF_W) / LEVELS;
  localparam int FRAME_W = PA_W - OFF_W;

  logic [VA_W-1:0]    vaddr_q;
  logic [FRAME_W-1:0] lvl_frame [LEVELS];
  logic [IDX_W-1:0]   lvl_idx   [LEVELS];
  logic [PA_W-1:0]    lvl_addr  [LEVELS];
  logic               end_ev, end_fault, end_level;
  logic               unused_low_bits;

  assign unused_low_bits = ^{req_dir_base[OFF_W-1:0], mem_rd_data[OFF_W-1:1]};

  for (genvar lv = 0; lv < LEVELS; lv++) begin : g_level
    localparam int LSB = OFF_W + (LEVELS - 1 - lv) * IDX_W;
    if (lv == 0) begin : g_root
      assign lvl_frame[lv] = req_dir_base[PA_W-1:OFF_W];
      assign lvl_idx[lv]   = req_vaddr[LSB +: IDX_W];
    end else begin : g_inner
      assign lvl_frame[lv] = mem_rd_data[PA_W-1:OFF_W];
      assign lvl_idx[lv]   = vaddr_q[LSB +: IDX_W];
    end
    ptw_entry_addr #(
      .PA_W(PA_W), .OFF_W(OFF_W), .IDX_W(IDX_W), .ENTRY_LOG2(ENTRY_LOG2)
    ) u_addr (
      .frame(lvl_frame[lv]),
      .idx  (lvl_idx[lv]),
      .addr (lvl_addr[lv])
    );
  end

  ptw_seq #(.VA_W(VA_W), .PA_W(PA_W)) u_seq (
    .clk          (clk),
    .rst          (rst),
    .req_valid    (req_valid),
    .req_vaddr    (req_vaddr),
    .dir_addr     (lvl_addr[0]),
    .pte_addr     (lvl_addr[1]),
    .mem_rd_valid (mem_rd_valid),
    .entry_present(mem_rd_data[0]),
    .mem_rd_req   (mem_rd_req),
    .mem_rd_addr  (mem_rd_addr),
    .busy         (busy),
    .vaddr_q      (vaddr_q),
    .end_ev       (end_ev),
    .end_fault    (end_fault),
    .end_level    (end_level)
  );

  ptw_resp #(.VA_W(VA_W), .PA_W(PA_W), .OFF_W(OFF_W)) u_resp (
    .clk        (clk),
    .rst        (rst),
    .end_ev     (end_ev),
    .end_fault  (end_fault),
    .end_level  (end_level),
    .end_frame  (mem_rd_data[PA_W-1:OFF_W]),
    .vaddr_q    (vaddr_q),
    .done       (done),
    .fault      (fault),
    .fault_level(fault_level),
    .resp_paddr (resp_paddr),
    .fill_valid (fill_valid),
    .fill_vpn   (fill_vpn),
    .fill_ppn   (fill_ppn)
  );
endmodule

// File: rtl/ptw_walker_chk.sv
module ptw_walker_chk #(
  parameter int VA_W  = 32,
  parameter int PA_W  = 32,
  parameter int OFF_W = 12
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  req_valid,
  input logic [VA_W-1:0]       req_vaddr,
  input logic                  busy,
  input logic                  mem_rd_req,
  input logic [PA_W-1:0]       mem_rd_addr,
  input logic                  mem_rd_valid,
  input logic                  done,
  input logic                  fault,
  input logic [PA_W-1:0]       resp_paddr,
  input logic                  fill_valid,
  input logic [VA_W-OFF_W-1:0] fill_vpn
);
  logic            open_rd;
  logic [VA_W-1:0] cap_va;

  always_ff @(posedge clk) begin
    if (rst) begin
      open_rd <= 1'b0;
      cap_va  <= '0;
    end else begin
      if (mem_rd_req)        open_rd <= 1'b1;
      else if (mem_rd_valid) open_rd <= 1'b0;
      if (!busy && req_valid) cap_va <= req_vaddr;
    end
  end

  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (!busy && !done && !mem_rd_req && !fill_valid));

  a_r2_accept_when_idle: assert property (@(posedge clk) disable iff (rst)
    (!busy && req_valid) |=> (busy && mem_rd_req));

  a_r3_addr_held: assert property (@(posedge clk) disable iff (rst)
    (open_rd && !mem_rd_valid) |=> $stable(mem_rd_addr));

  a_r5_single_read: assert property (@(posedge clk) disable iff (rst)
    mem_rd_req |-> !open_rd);

  a_r6_offset_passes: assert property (@(posedge clk) disable iff (rst)
    (done && !fault) |-> (resp_paddr[OFF_W-1:0] == cap_va[OFF_W-1:0]));

  a_r9_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> (!done && !busy));

  a_r10_fill_on_success: assert property (@(posedge clk) disable iff (rst)
    fill_valid |-> (done && !fault && fill_vpn == cap_va[VA_W-1:OFF_W]));

  a_r10_fault_no_addr: assert property (@(posedge clk) disable iff (rst)
    (done && fault) |-> (resp_paddr == '0 && !fill_valid));
endmodule

bind ptw_walker ptw_walker_chk #(.VA_W(VA_W), .PA_W(PA_W), .OFF_W(OFF_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .req_valid   (req_valid),
  .req_vaddr   (req_vaddr),
  .busy        (busy),
  .mem_rd_req  (mem_rd_req),
  .mem_rd_addr (mem_rd_addr),
  .mem_rd_valid(mem_rd_valid),
  .done        (done),
  .fault       (fault),
  .resp_paddr  (resp_paddr),
  .fill_valid  (fill_valid),
  .fill_vpn    (fill_vpn)
);

// File: tb/tb_ptw_walker.sv
`timescale 1ns/1ps
module tb_ptw_walker;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic [31:0] req_dir_base = '0;
  logic        busy, mem_rd_req, done, fault, fault_level, fill_valid;
  logic [31:0] mem_rd_addr, resp_paddr;
  logic        mem_rd_valid;
  logic [31:0] mem_rd_data;
  logic [19:0] fill_vpn, fill_ppn;

  always #2.5 clk = ~clk;

  ptw_walker dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_vaddr(req_vaddr),
    .req_dir_base(req_dir_base), .busy(busy), .mem_rd_req(mem_rd_req),
    .mem_rd_addr(mem_rd_addr), .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data),
    .done(done), .fault(fault), .fault_level(fault_level), .resp_paddr(resp_paddr),
    .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_ppn(fill_ppn)
  );

  // memory model: word array over byte address bits 13:2
  logic [31:0] mem [0:4095];
  logic        mdl_valid = 1'b0;
  logic [31:0] mdl_data  = '0;
  logic        stray_valid = 1'b0;
  logic [31:0] stray_data  = '0;
  logic        pend = 1'b0;
  logic [31:0] pend_addr = '0;
  int          cnt = 0;
  int          mem_lat = 0;
  int          rd_n = 0;
  logic [31:0] rd_log [4];

  assign mem_rd_valid = mdl_valid | stray_valid;
  assign mem_rd_data  = mdl_valid ? mdl_data : stray_data;

  always @(posedge clk) begin
    mdl_valid <= 1'b0;
    if (mem_rd_req) begin
      rd_log[rd_n % 4] <= mem_rd_addr;
      rd_n      <= rd_n + 1;
      pend      <= 1'b1;
      pend_addr <= mem_rd_addr;
      cnt       <= mem_lat;
    end else if (pend) begin
      if (cnt == 0) begin
        mdl_valid <= 1'b1;
        mdl_data  <= mem[pend_addr[13:2]];
        pend      <= 1'b0;
      end else begin
        cnt <= cnt - 1;
      end
    end
  end

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  task automatic chk(input bit ok, input string req, input [31:0] act, input [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected done", cyc);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  typedef struct packed {
    logic [31:0] va;
    logic [31:0] base;
    logic [3:0]  lat;
    logic        flt;
    logic        lvl;
    logic [1:0]  nrd;
    logic [31:0] a0;
    logic [31:0] a1;
    logic [31:0] pa;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{32'h0000_0123, 32'h0000_0ABC, 4'd0, 1'b0, 1'b0, 2'd2, 32'h0000_0000, 32'h0000_1000, 32'hABCD_E123},
    '{32'h003F_FFFF, 32'h0000_0000, 4'd1, 1'b0, 1'b0, 2'd2, 32'h0000_0000, 32'h0000_1FFC, 32'h1234_5FFF},
    '{32'h0160_0000, 32'h0000_0FFF, 4'd2, 1'b0, 1'b0, 2'd2, 32'h0000_0014, 32'h0000_2800, 32'hFEDC_B000},
    '{32'hFFC0_0456, 32'h0000_0000, 4'd3, 1'b0, 1'b0, 2'd2, 32'h0000_0FFC, 32'h0000_3000, 32'h8000_0456},
    '{32'h01C0_0010, 32'h0000_0000, 4'd1, 1'b1, 1'b0, 2'd1, 32'h0000_001C, 32'h0000_0000, 32'h0000_0000},
    '{32'h0000_3ABC, 32'h0000_0000, 4'd2, 1'b1, 1'b1, 2'd2, 32'h0000_0000, 32'h0000_100C, 32'h0000_0000},
    '{32'h0080_0000, 32'h0000_0000, 4'd0, 1'b1, 1'b0, 2'd1, 32'h0000_0008, 32'h0000_0000, 32'h0000_0000},
    '{32'h0140_0001, 32'h0000_0000, 4'd4, 1'b1, 1'b1, 2'd2, 32'h0000_0014, 32'h0000_2000, 32'h0000_0000},
    '{32'h0000_2007, 32'h0000_3777, 4'd1, 1'b1, 1'b1, 2'd2, 32'h0000_3000, 32'h8000_0008, 32'h0000_0000},
    '{32'h8000_0009, 32'h0000_2000, 4'd5, 1'b0, 1'b0, 2'd2, 32'h0000_2800, 32'hFEDC_B000, 32'h8000_0009}
  };

  // walk outcome, sampled at the negedge of the done cycle
  logic        g_fault, g_lvl, g_fill;
  logic [31:0] g_pa;
  logic [19:0] g_vpn, g_ppn;
  int          g_reads, g_base;

  task automatic start_walk(input [31:0] va, input [31:0] base, input int lat);
    @(negedge clk);
    mem_lat      = lat;
    g_base       = rd_n;
    req_valid    = 1'b1;
    req_vaddr    = va;
    req_dir_base = base;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic finish_walk(input string tag);
    int w;
    w = 0;
    while (!done && w < 300) begin
      @(negedge clk);
      w++;
    end
    chk(done == 1'b1, {tag, " R9 done seen"}, {31'd0, done}, 32'd1);
    chk(busy == 1'b1, {tag, " R9 busy in done cycle"}, {31'd0, busy}, 32'd1);
    g_fault = fault;
    g_lvl   = fault_level;
    g_fill  = fill_valid;
    g_pa    = resp_paddr;
    g_vpn   = fill_vpn;
    g_ppn   = fill_ppn;
    @(negedge clk);
    g_reads = rd_n - g_base;
    chk(done == 1'b0 && busy == 1'b0, {tag, " R9 pulse ends"}, {30'd0, done, busy}, 32'd0);
  endtask

  initial begin
    for (int i = 0; i < 4096; i++) mem[i] = '0;
    mem[0]         = 32'h0000_1001;
    mem[5]         = 32'h0000_2001;
    mem[7]         = 32'h0000_2000;
    mem[1023]      = 32'h0000_3001;
    mem[1024]      = 32'hABCD_E001;
    mem[1024+3]    = 32'h5555_5000;
    mem[1024+1023] = 32'h1234_5001;
    mem[2048+512]  = 32'hFEDC_B003;
    mem[3072]      = 32'h8000_0001;

    // R1: reset state
    repeat (3) @(negedge clk);
    chk(!busy && !done && !mem_rd_req && !fill_valid, "R1 reset outputs",
        {28'd0, busy, done, mem_rd_req, fill_valid}, 32'd0);
    rst = 1'b0;

    // R5: stray read-valid while idle has no effect
    @(negedge clk);
    stray_valid = 1'b1;
    stray_data  = 32'h1111_1001;
    repeat (2) @(negedge clk);
    stray_valid = 1'b0;
    chk(!busy && !done && !mem_rd_req, "R5 stray valid ignored",
        {29'd0, busy, done, mem_rd_req}, 32'd0);

    // vector table: R3 R4 R6 R7 R8 R10 R11
    for (int v = 0; v < NV; v++) begin
      start_walk(VECS[v].va, VECS[v].base, int'(VECS[v].lat));
      chk(busy == 1'b1, "R2 busy after accept", {31'd0, busy}, 32'd1);
      chk(mem_rd_req && mem_rd_addr == VECS[v].a0, "R3 directory read address",
          mem_rd_addr, VECS[v].a0);
      finish_walk("vec");
      chk(g_reads == int'(VECS[v].nrd), "R7 R8 read count", g_reads, {30'd0, VECS[v].nrd});
      chk(rd_log[g_base % 4] == VECS[v].a0, "R3 logged directory address",
          rd_log[g_base % 4], VECS[v].a0);
      if (VECS[v].nrd == 2'd2)
        chk(rd_log[(g_base + 1) % 4] == VECS[v].a1, "R4 page table read address",
            rd_log[(g_base + 1) % 4], VECS[v].a1);
      chk(g_fault == VECS[v].flt, "R6 R7 R8 fault flag", {31'd0, g_fault}, {31'd0, VECS[v].flt});
      if (VECS[v].flt)
        chk(g_lvl == VECS[v].lvl, "R7 R8 fault level", {31'd0, g_lvl}, {31'd0, VECS[v].lvl});
      chk(g_pa == VECS[v].pa, "R6 R11 physical address", g_pa, VECS[v].pa);
      chk(g_fill == !VECS[v].flt, "R10 fill valid", {31'd0, g_fill}, {31'd0, !VECS[v].flt});
      if (!VECS[v].flt)
        chk(g_vpn == VECS[v].va[31:12] && g_ppn == VECS[v].pa[31:12], "R10 fill record",
            {g_vpn[11:0], g_ppn}, {VECS[v].va[23:12], VECS[v].pa[31:12]});
    end

    // R2: request during a walk is ignored
    start_walk(32'h0000_0123, 32'h0, 6);
    req_valid = 1'b1;
    req_vaddr = 32'hFFC0_0456;
    repeat (3) @(negedge clk);
    req_valid = 1'b0;
    finish_walk("busy-req");
    chk(g_pa == 32'hABCD_E123, "R2 walk keeps its own request", g_pa, 32'hABCD_E123);
    chk(g_reads == 2, "R2 no extra walk reads", g_reads, 32'd2);
    repeat (3) @(negedge clk);
    chk(!busy && (rd_n - g_base) == 2, "R2 no walk after ignored request",
        {31'd0, busy}, 32'd0);

    // R1: reset during a walk, late response ignored
    start_walk(32'h003F_FFFF, 32'h0, 10);
    repeat (2) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !mem_rd_req, "R1 reset aborts walk",
        {29'd0, busy, done, mem_rd_req}, 32'd0);
    rst = 1'b0;
    begin
      bit seen;
      seen = 1'b0;
      repeat (15) begin
        @(negedge clk);
        if (done || busy) seen = 1'b1;
      end
      chk(!seen, "R1 R5 stale response after reset ignored", {31'd0, seen}, 32'd0);
    end

    // R11: walk after reset with long wait
    start_walk(32'h0160_0000, 32'h0, 12);
    finish_walk("post-reset");
    chk(!g_fault && g_pa == 32'hFEDC_B000, "R11 long wait result", g_pa, 32'hFEDC_B000);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule